// File: doc/BRIEF.md
# Memory Fence Ordering Unit

This block sits between one core's in-order stream of memory requests and the memory system, and enforces weak-consistency barriers on that stream. Each request is either a data operation or a fence. Data operations are granted to memory as they arrive and counted in a small up/down tally of operations still in flight: the tally rises on every grant and falls on every completion pulse from memory. Data operations may finish in any order; the block only counts them.

A fence is a barrier. Once a fence is accepted, nothing else is granted. The fence retires when the in-flight tally has drained to zero. A one-cycle retire pulse then marks the end of the fence, and the next request may be granted during that pulse. Fences are handled one at a time, in the order they arrive. The tally saturates rather than wrapping. A completion pulse that arrives with nothing in flight sets a sticky error flag.

The requester holds a request on the input, with its kind, until the block accepts it. Acceptance is combinational in the same cycle.

Top module: `fence_order_unit`

## Requirements
- R1: After a synchronous active-low reset, `inflight` is 0, `fence_done` is 0, `underflow_err` is 0, and no fence is pending.
- R2: When no fence is pending and `inflight` is below its maximum, a valid data request (`op_is_fence` = 0) sees `op_ready` and `mem_issue` high in the same cycle, and `inflight` is one higher after the clock edge.
- R3: A `mem_done` pulse with no grant in the same cycle lowers `inflight` by one at the next edge when `inflight` is nonzero.
- R4: A grant and a `mem_done` pulse in the same cycle, with `inflight` nonzero, leave `inflight` unchanged.
- R5: `inflight` is 6 bits wide. At 63, data requests are refused (`op_ready` = 0, `mem_issue` = 0) even if `mem_done` pulses in that cycle, so the tally never wraps.
- R6: A valid fence request (`op_is_fence` = 1) is accepted with `op_ready` high when no fence is pending. From the next cycle until the fence retires, `op_ready` and `mem_issue` stay low for every request.
- R7: A pending fence retires at the first edge that ends a cycle in which `inflight` reads 0. `fence_done` is then high for exactly one cycle, and a new request may be accepted in that same cycle.
- R8: Fences are processed strictly in order. A fence that arrives while another is pending waits. It may be accepted in the cycle in which `fence_done` is high, and it produces its own separate `fence_done` pulse.
- R9: A `mem_done` pulse while `inflight` is 0 leaves `inflight` at 0 and sets `underflow_err` from the next edge. The flag stays set until reset.
- R10: Accepting a fence never raises `mem_issue` and does not change `inflight`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | A request is presented |
| op_is_fence | input | 1 | Kind of the presented request: 1 = fence, 0 = data operation |
| op_ready | output | 1 | The presented request is accepted this cycle |
| mem_issue | output | 1 | A data operation is granted to memory this cycle |
| mem_done | input | 1 | One data operation completed in memory this cycle |
| fence_done | output | 1 | One-cycle pulse when a fence retires |
| inflight | output | 6 | Number of granted data operations not yet completed |
| underflow_err | output | 1 | Sticky: a completion arrived with nothing in flight |

## Verification
A grant to memory and a completion from memory can fall in the same cycle, and each of them moves the in-flight tally in the opposite direction. The stimulus table drives a data request together with a `mem_done` pulse while operations are outstanding. It then reads `inflight` after the edge and expects the old value. The same collision is set up at the saturation limit, where the grant must be refused and only the completion counted, so the tally must drop by one. A completion into an empty tally is also driven, where the pulse must be dropped and the error flag raised.

// File: rtl/fou_pkg.sv
// Shared types for the fence ordering unit.
// Assumes nothing beyond a single in-order request stream.
package fou_pkg;

    // Barrier sequencer state: open for requests, or draining for a fence
    typedef enum logic [0:0] {
        FS_OPEN  = 1'b0,
        FS_DRAIN = 1'b1
    } fence_st_t;

endpackage

// File: rtl/fou_inflight_ctr.sv
// Up/down tally of data operations granted to memory but not yet completed.
// Assumes at most one grant and one completion per cycle. A completion seen
// at zero is dropped and reported on the stray output for one cycle.
module fou_inflight_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_full,
    output logic             stray
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             dec_ok;

    // A completion only counts when something is in flight
    always_comb begin
        dec_ok  = dec && (cnt_q != '0);
        stray   = dec && (cnt_q == '0);
        is_zero = (cnt_q == '0);
        is_full = (cnt_q == CNT_TOP);
    end

    // Tally update: a grant and a completion together cancel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/fou_fence_seq.sv
// Barrier sequencer. An accepted fence closes the gate until the in-flight
// tally reads zero. The fence then retires with a one-cycle pulse, and the
// gate reopens during that pulse. Only one fence is held at a time, so fences
// retire in arrival order.
module fou_fence_seq
    import fou_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fence_take,
    input  logic drained,
    output logic gate_open,
    output logic retire
);
    fence_st_t st_q;
    logic      retire_q;

    // Next state and retire pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= FS_OPEN;
            retire_q <= 1'b0;
        end else begin
            retire_q <= 1'b0;
            case (st_q)
                FS_OPEN: begin
                    if (fence_take) st_q <= FS_DRAIN;
                end
                FS_DRAIN: begin
                    if (drained) begin
                        st_q     <= FS_OPEN;
                        retire_q <= 1'b1;
                    end
                end
                default: st_q <= FS_OPEN;
            endcase
        end
    end

    // Gate is open whenever no fence is pending
    always_comb begin
        gate_open = (st_q == FS_OPEN);
    end

    assign retire = retire_q;
endmodule

// File: rtl/fou_err_latch.sv
// Sticky flag: set by any one-cycle event, cleared only by reset.
module fou_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic flag
);
    logic flag_q;

    // Hold the flag once set
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
    end

    assign flag = flag_q;
endmodule

// File: rtl/fence_order_unit.sv
// Fence ordering unit for one core's request stream.
// Data requests are granted while no fence is pending and the tally is not
// full. A fence is accepted when no fence is pending, and it blocks all
// requests until the in-flight tally drains. Assumes that the requester holds
// a request steady until op_ready, and that mem_done pulses once per finished
// data operation.
module fence_order_unit #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_is_fence,
    output logic             op_ready,
    output logic             mem_issue,
    input  logic             mem_done,
    output logic             fence_done,
    output logic [CNT_W-1:0] inflight,
    output logic             underflow_err
);
    logic gate_open;
    logic tally_zero;
    logic tally_full;
    logic stray_done;
    logic fence_take;

    // Acceptance and grant decode
    always_comb begin
        op_ready   = op_valid && gate_open && (op_is_fence || !tally_full);
        mem_issue  = op_ready && !op_is_fence;
        fence_take = op_ready && op_is_fence;
    end

    fou_inflight_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (mem_issue),
        .dec     (mem_done),
        .count   (inflight),
        .is_zero (tally_zero),
        .is_full (tally_full),
        .stray   (stray_done)
    );

    fou_fence_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fence_take (fence_take),
        .drained    (tally_zero),
        .gate_open  (gate_open),
        .retire     (fence_done)
    );

    fou_err_latch u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stray_done),
        .flag  (underflow_err)
    );
endmodule

// File: rtl/fou_checks.sv
// Port-level checker for the fence ordering unit, bound to every instance.
module fou_checks #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             op_is_fence,
    input logic             op_ready,
    input logic             mem_issue,
    input logic             mem_done,
    input logic             fence_done,
    input logic [CNT_W-1:0] inflight,
    input logic             underflow_err
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R2
    issue_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_issue && !mem_done) |=> (inflight == $past(inflight) + 1'b1));

    // R3
    done_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_issue && mem_done && inflight != '0) |=> (inflight == $past(inflight) - 1'b1));

    // R4
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_issue && mem_done && inflight != '0) |=> $stable(inflight));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == TOP) |-> !mem_issue);

    // R6
    drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_is_fence && op_ready) |=> !op_ready);

    // R7
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |=> !fence_done);

    // R7
    retire_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> ($past(inflight) == '0));

    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_done && !mem_issue && inflight == '0) |=> (underflow_err && inflight == '0));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);

    // R10
    fence_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_is_fence) |-> !mem_issue);
endmodule

bind fence_order_unit fou_checks #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_is_fence   (op_is_fence),
    .op_ready      (op_ready),
    .mem_issue     (mem_issue),
    .mem_done      (mem_done),
    .fence_done    (fence_done),
    .inflight      (inflight),
    .underflow_err (underflow_err)
);

// File: tb/sim_fence_order_unit.sv
module sim_fence_order_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic       op_is_fence = 1'b0;
    logic       mem_done = 1'b0;
    logic       op_ready;
    logic       mem_issue;
    logic       fence_done;
    logic [5:0] inflight;
    logic       underflow_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fence_order_unit #(.CNT_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_fence(op_is_fence),
        .op_ready(op_ready), .mem_issue(mem_issue), .mem_done(mem_done),
        .fence_done(fence_done), .inflight(inflight), .underflow_err(underflow_err)
    );

    // Row: {valid, fence, done, exp_ready, exp_issue, exp_fdone, exp_inflight}
    // Expected values are those seen during the row's cycle, before its edge.
    localparam logic [11:0] TBL [16] = '{
        12'b100_110_000000, // R2 grant from empty
        12'b100_110_000001, // R2 second grant
        12'b101_110_000010, // R4 grant and completion together
        12'b001_000_000010, // R3 completion alone
        12'b110_100_000001, // R6 fence accepted with one in flight
        12'b100_000_000001, // R6 data held behind fence
        12'b101_000_000001, // R6 last completion
        12'b100_000_000000, // R7 drained, retires at this edge
        12'b100_111_000000, // R7 pulse, grant in the same cycle
        12'b110_100_000001, // R8 first fence accepted
        12'b111_000_000001, // R8 second fence waits
        12'b110_000_000000, // R8 drained
        12'b110_101_000000, // R8 pulse, second fence accepted
        12'b000_000_000000, // R8 draining empty
        12'b000_001_000000, // R8 second pulse
        12'b000_000_000000  // R7 pulse over
    };

    function automatic string row_tag(input int i);
        if (i == 2)                 return "R4";
        else if (i == 3)            return "R3";
        else if (i >= 4 && i <= 6)  return "R6";
        else if (i >= 9 && i <= 14) return "R8";
        else if (i == 7 || i == 8)  return "R7";
        else                        return "R2";
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic f, input logic d);
        @(negedge clk);
        op_valid = v;
        op_is_fence = f;
        mem_done = d;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "inflight", int'(inflight), 0);
        chk("R1", "fence_done", int'(fence_done), 0);
        chk("R1", "underflow_err", int'(underflow_err), 0);

        for (int i = 0; i < 16; i++) begin
            step(TBL[i][11], TBL[i][10], TBL[i][9]);
            chk(row_tag(i), "op_ready", int'(op_ready), int'(TBL[i][8]));
            chk(row_tag(i), "mem_issue", int'(mem_issue), int'(TBL[i][7]));
            chk(row_tag(i), "fence_done", int'(fence_done), int'(TBL[i][6]));
            chk(row_tag(i), "inflight", int'(inflight), int'(TBL[i][5:0]));
        end

        // R9 completion into an empty tally
        step(0, 0, 1);
        chk("R9", "err before edge", int'(underflow_err), 0);
        step(0, 0, 0);
        chk("R9", "err set", int'(underflow_err), 1);
        chk("R9", "inflight kept", int'(inflight), 0);
        step(1, 0, 0);
        chk("R9", "grant after err", int'(mem_issue), 1);
        step(0, 0, 1);
        chk("R9", "inflight", int'(inflight), 1);
        step(0, 0, 0);
        chk("R9", "err sticky", int'(underflow_err), 1);
        chk("R3", "inflight drained", int'(inflight), 0);

        // R5 saturation
        for (int k = 0; k < 63; k++) step(1, 0, 0);
        step(1, 0, 0);
        chk("R5", "inflight full", int'(inflight), 63);
        chk("R5", "op_ready at full", int'(op_ready), 0);
        chk("R5", "mem_issue at full", int'(mem_issue), 0);
        step(1, 0, 1);
        chk("R5", "op_ready full with done", int'(op_ready), 0);
        step(0, 0, 0);
        chk("R5", "inflight after done", int'(inflight), 62);

        // R1 reset from a busy state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R1", "inflight after reset", int'(inflight), 0);
        chk("R1", "err after reset", int'(underflow_err), 0);
        chk("R1", "fence_done after reset", int'(fence_done), 0);
        rst_n = 1'b1;

        // R10 fence on empty tally does not count
        step(1, 1, 0);
        chk("R10", "fence op_ready", int'(op_ready), 1);
        chk("R10", "fence mem_issue", int'(mem_issue), 0);
        step(0, 0, 0);
        chk("R10", "inflight after fence", int'(inflight), 0);
        chk("R7", "no pulse yet", int'(fence_done), 0);
        step(0, 0, 0);
        chk("R7", "pulse", int'(fence_done), 1);
        step(0, 0, 0);
        chk("R7", "pulse ends", int'(fence_done), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule